// File: doc/BRIEF.md
# Outbound Message Error Status Controller

This block watches the error events of an outbound message engine. The engine sends each message as a run of segments, and it builds each segment from reads of local memory. Four error sources feed the block:

- a negative response from the far end;
- a response that never arrived in time;
- a retry count that went past its limit;
- a local memory read that came back with an internal fault.

Each source latches into its own sticky status bit. When interrupts are enabled, any latched error raises one shared interrupt line. The engine is not cut off at once: it runs until the current message operation finishes, which shows as the busy bit dropping. While an error is latched, no new operation is accepted.

An internal memory fault has an extra effect on the message it belongs to. From the faulting read onward, returning read data is thrown away. This covers data from reads issued before the fault and from reads issued after it. Every later segment of that message, retried segments included, is held back. The hold lifts when the operation ends, so the next message after recovery goes out normally.

Software reaches the block through a two-register port:

- a mode register, which holds the engine enable and the interrupt enable;
- a status register, which holds the busy flag and four write-one-to-clear error bits.

Recovery runs in this order: software waits for busy to clear, turns off the engine enable, and then clears the error bits.

Top module: `omsg_err_ctrl`

## Requirements
- R1: After reset, the mode register reads 0, the status register reads 0, err_irq is 0 and op_busy is 0.
- R2: Each error input latches its own status bit, and the bit stays set until software clears it. The bits are: bit 1 for error response, bit 2 for response timeout, bit 3 for retry limit, and bit 4 for internal memory error. A status bit appears on reg_rdata (reg_sel=1) one cycle after its event.
- R3: Writing status (reg_sel=1) with a 1 in a bit position 1..4 clears that error bit, and a 0 leaves it unchanged. Bit 0 (busy) ignores writes. An event in the same cycle as its clear leaves the bit set.
- R4: err_irq is 1 exactly when the interrupt-enable bit (mode bit 1) is 1 and at least one error status bit is set.
- R5: start_ack goes high in the cycle of start_req only when the engine enable (mode bit 0) is 1, no error bit is set and the engine is not busy. An accepted start makes op_busy 1 from the next cycle.
- R6: op_busy stays 1 until op_done is seen, whatever errors occur in the meantime, and goes to 0 in the cycle after op_done.
- R7: rd_data_fwd is 0 whenever ev_mem_err is 1 in that cycle. Once a memory error has been seen during a busy operation, rd_data_fwd stays 0 until the cycle after op_done.
- R8: seg_send follows the same suppression as R7, so no segment is sent while suppression is active, and that includes retried segments. Outside suppression, seg_send equals seg_valid.
- R9: Suppression clears in the cycle after op_done, so the next operation forwards reads and sends segments normally.
- R10: The mode register reads back enable in bit 0 and interrupt enable in bit 1. All other bits of either register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 mode, 1 status |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Read data of the selected register |
| start_req | input | 1 | Request to begin a message operation |
| start_ack | output | 1 | Start accepted this cycle |
| op_done | input | 1 | Current message operation has ended |
| ev_err_resp | input | 1 | Error response received |
| ev_resp_timeout | input | 1 | Response timeout |
| ev_retry_limit | input | 1 | Retry limit exceeded |
| ev_mem_err | input | 1 | Internal error on a local memory read |
| rd_data_valid | input | 1 | Memory read data returned |
| rd_data_fwd | output | 1 | Read data may be passed to segmentation |
| seg_valid | input | 1 | Segment (new or retried) ready to send |
| seg_send | output | 1 | Segment may go to the link |
| op_busy | output | 1 | Message operation in progress |
| err_irq | output | 1 | Shared error interrupt |

## Verification
The hardest state to reach from the ports is a memory fault in the middle of a busy operation, followed by further reads and retried segments, an op_done, a full recovery and a second, clean message. Reaching it takes a correct order of mode writes, starts, events and clears. Directed sequences walk that path explicitly, and they also hit an event and its clear landing in the same cycle. Seeded random traffic then mixes register writes, starts, completions and sparse error events, so that faults land at every point of an operation.

// File: rtl/omsg_err_pkg.sv
// Shared constants for the outbound message error status controller.
// Assumes the register data width is at least ERR_LSB + NUM_ERR bits.
package omsg_err_pkg;
    localparam int NUM_ERR  = 4;
    localparam int MODE_EN  = 0;
    localparam int MODE_IE  = 1;
    localparam int STAT_BSY = 0;
    localparam int ERR_LSB  = 1;
    localparam int ERR_MEM  = 3;   // index of internal memory error in the error vector

    typedef enum logic {
        SEL_MODE = 1'b0,
        SEL_STAT = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/omsg_err_sticky.sv
// Bank of sticky error bits: each sets on its event and clears on a
// write-one-to-clear strobe. A set and a clear in the same cycle leave the bit set.
module omsg_err_sticky #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] q_o
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        // One sticky bit; set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        q_o[i] <= 1'b0;
            else if (set_i[i]) q_o[i] <= 1'b1;
            else if (clr_i[i]) q_o[i] <= 1'b0;
        end
    end
endmodule

// File: rtl/omsg_err_engine.sv
// Mode register and operation tracker. It accepts a start only when the
// engine is enabled, no error is latched and no operation is running.
// Busy is released only by op_done, so an error lets the current message finish.
module omsg_err_engine (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_mode,
    input  logic wd_en,
    input  logic wd_ie,
    input  logic start_req,
    input  logic op_done,
    input  logic err_any,
    output logic en_o,
    output logic ie_o,
    output logic busy_o,
    output logic ack_o
);
    // Start acceptance condition.
    always_comb ack_o = start_req && en_o && !err_any && !busy_o;

    // Mode register bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_o <= 1'b0;
            ie_o <= 1'b0;
        end else if (wr_mode) begin
            en_o <= wd_en;
            ie_o <= wd_ie;
        end
    end

    // Operation busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       busy_o <= 1'b0;
        else if (ack_o)   busy_o <= 1'b1;
        else if (op_done) busy_o <= 1'b0;
    end
endmodule

// File: rtl/omsg_err_gate.sv
// Traffic gate for internal memory errors. Read data and segments are
// blocked in the fault cycle. They stay blocked for the rest of the
// operation (if the fault came while busy) until op_done.
module omsg_err_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic op_done,
    input  logic mem_err,
    input  logic rd_valid,
    input  logic seg_valid,
    output logic rd_fwd,
    output logic seg_send,
    output logic drop_q
);
    logic drop_now;

    // Blocking applies in the fault cycle itself and while the flag is held.
    always_comb begin
        drop_now = drop_q || mem_err;
        rd_fwd   = rd_valid && !drop_now;
        seg_send = seg_valid && !drop_now;
    end

    // Suppression flag, ended by completion of the operation.
    always_ff @(posedge clk) begin
        if (!rst_n)                 drop_q <= 1'b0;
        else if (op_done)           drop_q <= 1'b0;
        else if (mem_err && busy)   drop_q <= 1'b1;
    end
endmodule

// File: rtl/omsg_err_ctrl.sv
// Outbound message error status controller, top level.
// Connects the sticky error bank, the mode and busy tracker and the traffic gate,
// and drives the register read mux and the shared interrupt.
// Assumes DW >= ERR_LSB + NUM_ERR and one register access per cycle.
module omsg_err_ctrl #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic          reg_sel,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          start_req,
    output logic          start_ack,
    input  logic          op_done,
    input  logic          ev_err_resp,
    input  logic          ev_resp_timeout,
    input  logic          ev_retry_limit,
    input  logic          ev_mem_err,
    input  logic          rd_data_valid,
    output logic          rd_data_fwd,
    input  logic          seg_valid,
    output logic          seg_send,
    output logic          op_busy,
    output logic          err_irq
);
    import omsg_err_pkg::*;

    localparam int ERR_MSB = ERR_LSB + NUM_ERR - 1;

    logic [NUM_ERR-1:0] ev_vec;
    logic [NUM_ERR-1:0] clr_vec;
    logic [NUM_ERR-1:0] err_q;
    logic               wr_mode, wr_stat;
    logic               en, ie, drop_q;

    // Decode the register write strobes and collect the event pulses.
    always_comb begin
        wr_mode = reg_wr && (reg_sel_e'(reg_sel) == SEL_MODE);
        wr_stat = reg_wr && (reg_sel_e'(reg_sel) == SEL_STAT);
        clr_vec = wr_stat ? reg_wdata[ERR_MSB:ERR_LSB] : '0;
        ev_vec  = {ev_mem_err, ev_retry_limit, ev_resp_timeout, ev_err_resp};
    end

    omsg_err_sticky #(.N(NUM_ERR)) u_sticky (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (ev_vec),
        .clr_i (clr_vec),
        .q_o   (err_q)
    );

    omsg_err_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_mode   (wr_mode),
        .wd_en     (reg_wdata[MODE_EN]),
        .wd_ie     (reg_wdata[MODE_IE]),
        .start_req (start_req),
        .op_done   (op_done),
        .err_any   (|err_q),
        .en_o      (en),
        .ie_o      (ie),
        .busy_o    (op_busy),
        .ack_o     (start_ack)
    );

    omsg_err_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .busy      (op_busy),
        .op_done   (op_done),
        .mem_err   (ev_vec[ERR_MEM]),
        .rd_valid  (rd_data_valid),
        .seg_valid (seg_valid),
        .rd_fwd    (rd_data_fwd),
        .seg_send  (seg_send),
        .drop_q    (drop_q)
    );

    // Register read mux and shared interrupt.
    always_comb begin
        reg_rdata = '0;
        if (reg_sel_e'(reg_sel) == SEL_MODE) begin
            reg_rdata[MODE_EN] = en;
            reg_rdata[MODE_IE] = ie;
        end else begin
            reg_rdata[STAT_BSY]        = op_busy;
            reg_rdata[ERR_MSB:ERR_LSB] = err_q;
        end
        err_irq = ie && (|err_q);
    end
endmodule

// File: rtl/omsg_err_ctrl_chk.sv
// Property checker for omsg_err_ctrl, attached through bind.
module omsg_err_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_stat,
    input logic [3:0] clr_vec,
    input logic [3:0] ev_vec,
    input logic [3:0] err_q,
    input logic       en,
    input logic       ie,
    input logic       op_busy,
    input logic       op_done,
    input logic       start_ack,
    input logic       ev_mem_err,
    input logic       rd_data_fwd,
    input logic       seg_send,
    input logic       err_irq,
    input logic       drop_q
);
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stat |=> ((err_q & $past(err_q)) == $past(err_q)));
    a_r3_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && clr_vec == 4'b0) |=> (err_q == ($past(err_q) | $past(ev_vec))));
    a_r3_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev_vec[0] |=> err_q[0]);
    a_r4_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        !ie |-> !err_irq);
    a_r4_irq_raised: assert property (@(posedge clk) disable iff (!rst_n)
        (ie && err_q != 4'b0) |-> err_irq);
    a_r5_ack_gated: assert property (@(posedge clk) disable iff (!rst_n)
        start_ack |-> (en && err_q == 4'b0 && !op_busy));
    a_r5_ack_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_ack |=> op_busy);
    a_r6_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (op_busy && !op_done) |=> op_busy);
    a_r7_fault_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ev_mem_err |-> (!rd_data_fwd && !seg_send));
    a_r8_after_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_mem_err && op_busy && !op_done) |=> (!rd_data_fwd && !seg_send));
    a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !drop_q);
endmodule

bind omsg_err_ctrl omsg_err_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_stat     (wr_stat),
    .clr_vec     (clr_vec),
    .ev_vec      (ev_vec),
    .err_q       (err_q),
    .en          (en),
    .ie          (ie),
    .op_busy     (op_busy),
    .op_done     (op_done),
    .start_ack   (start_ack),
    .ev_mem_err  (ev_mem_err),
    .rd_data_fwd (rd_data_fwd),
    .seg_send    (seg_send),
    .err_irq     (err_irq),
    .drop_q      (drop_q)
);

// File: tb/omsg_err_ctrl_tb.sv
// Bench: directed recovery and corner sequences, then seeded random traffic,
// all compared cycle by cycle against a reference model kept in the bench.
module omsg_err_ctrl_tb;
    localparam int CLK_P = 10;
    localparam int DW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 0, reg_sel = 0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          start_req = 0, start_ack, op_done = 0;
    logic          ev_err_resp = 0, ev_resp_timeout = 0, ev_retry_limit = 0, ev_mem_err = 0;
    logic          rd_data_valid = 0, rd_data_fwd, seg_valid = 0, seg_send, op_busy, err_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done_flag = 0;

    // Reference model state.
    logic       m_en, m_ie, m_busy, m_drop;
    logic [3:0] m_err;

    always #(CLK_P/2) clk = ~clk;

    omsg_err_ctrl #(.DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .start_req(start_req),
        .start_ack(start_ack), .op_done(op_done), .ev_err_resp(ev_err_resp),
        .ev_resp_timeout(ev_resp_timeout), .ev_retry_limit(ev_retry_limit),
        .ev_mem_err(ev_mem_err), .rd_data_valid(rd_data_valid),
        .rd_data_fwd(rd_data_fwd), .seg_valid(seg_valid), .seg_send(seg_send),
        .op_busy(op_busy), .err_irq(err_irq)
    );

    function automatic logic [DW-1:0] exp_rdata(logic sel);
        logic [DW-1:0] v = '0;
        if (sel) begin v[0] = m_busy; v[4:1] = m_err; end
        else begin v[0] = m_en; v[1] = m_ie; end
        return v;
    endfunction

    function automatic logic exp_ack(logic st);
        return st && m_en && (m_err == 4'b0) && !m_busy;
    endfunction

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: drive, check the outputs, then advance the model at the edge.
    task automatic cyc(logic wr, logic sel, logic [DW-1:0] wd, logic st, logic dn,
                       logic [3:0] ev, logic rv, logic sv);
        logic       ack, dnow, n_en, n_ie, n_busy, n_drop;
        logic [3:0] n_err, clr;
        reg_wr = wr; reg_sel = sel; reg_wdata = wd; start_req = st; op_done = dn;
        {ev_mem_err, ev_retry_limit, ev_resp_timeout, ev_err_resp} = ev;
        rd_data_valid = rv; seg_valid = sv;
        #2;
        ack  = exp_ack(st);
        dnow = m_drop || ev[3];
        check("R2 R3 R10 rdata", reg_rdata, exp_rdata(sel));
        check("R4 irq", DW'(err_irq), DW'(m_ie && (m_err != 0)));
        check("R5 ack", DW'(start_ack), DW'(ack));
        check("R5 R6 busy", DW'(op_busy), DW'(m_busy));
        check("R7 R9 rd_fwd", DW'(rd_data_fwd), DW'(rv && !dnow));
        check("R8 R9 seg_send", DW'(seg_send), DW'(sv && !dnow));
        clr    = (wr && sel) ? wd[4:1] : 4'b0;
        n_err  = (m_err & ~clr) | ev;
        n_en   = (wr && !sel) ? wd[0] : m_en;
        n_ie   = (wr && !sel) ? wd[1] : m_ie;
        n_busy = ack ? 1'b1 : (dn ? 1'b0 : m_busy);
        n_drop = dn ? 1'b0 : (m_drop || (ev[3] && m_busy));
        @(posedge clk); #1;
        m_err = n_err; m_en = n_en; m_ie = n_ie; m_busy = n_busy; m_drop = n_drop;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, 0, '0, 0, 0, 4'b0, 0, 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        if (!done_flag) $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_en = 0; m_ie = 0; m_busy = 0; m_drop = 0; m_err = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state
        #1;
        check("R1 mode", reg_rdata, '0);
        check("R1 irq", DW'(err_irq), '0);
        check("R1 busy", DW'(op_busy), '0);
        reg_sel = 1; #1;
        check("R1 status", reg_rdata, '0);
        @(posedge clk); #1;

        // R5: start refused while disabled, then accepted when enabled.
        cyc(0, 0, '0, 1, 0, 4'b0, 0, 0);
        cyc(1, 0, 8'h03, 0, 0, 4'b0, 0, 0);
        cyc(0, 1, '0, 1, 0, 4'b0, 1, 1);
        // R2 R4 R6: each non-memory error latches; busy holds until done.
        cyc(0, 1, '0, 0, 0, 4'b0001, 1, 1);
        cyc(0, 1, '0, 0, 0, 4'b0010, 0, 0);
        cyc(0, 1, '0, 0, 0, 4'b0100, 0, 0);
        cyc(0, 1, '0, 1, 0, 4'b0000, 0, 0);
        cyc(0, 1, '0, 0, 1, 4'b0000, 0, 0);
        // R3: write zero keeps, busy bit ignores writes, set wins over clear.
        cyc(1, 1, 8'h01, 0, 0, 4'b0000, 0, 0);
        cyc(1, 1, 8'h02, 0, 0, 4'b0001, 0, 0);
        cyc(1, 0, 8'h02, 0, 0, 4'b0000, 0, 0);
        cyc(1, 1, 8'h1E, 0, 0, 4'b0000, 0, 0);
        cyc(1, 0, 8'h03, 0, 0, 4'b0000, 0, 0);
        // R7 R8: memory fault mid-message blocks reads and retried segments.
        cyc(0, 1, '0, 1, 0, 4'b0, 0, 0);
        cyc(0, 1, '0, 0, 0, 4'b0, 1, 1);
        cyc(0, 1, '0, 0, 0, 4'b1000, 1, 1);
        for (int i = 0; i < 4; i++) cyc(0, 1, '0, 0, 0, 4'b0, 1, 1);
        cyc(0, 1, '0, 0, 1, 4'b0, 1, 1);
        // R9: recovery in order, then a clean second message.
        cyc(1, 0, 8'h02, 0, 0, 4'b0, 1, 1);
        cyc(1, 1, 8'h1E, 0, 0, 4'b0, 0, 0);
        cyc(1, 0, 8'h03, 0, 0, 4'b0, 0, 0);
        cyc(0, 1, '0, 1, 0, 4'b0, 0, 0);
        for (int i = 0; i < 3; i++) cyc(0, 1, '0, 0, 0, 4'b0, 1, 1);
        cyc(0, 1, '0, 0, 1, 4'b0, 1, 1);
        idle(2);

        // Seeded random traffic.
        void'($urandom(32'h5eed_0a11));
        for (int i = 0; i < 4000; i++) begin
            logic [3:0] ev;
            for (int k = 0; k < 4; k++) ev[k] = ($urandom_range(0, 39) == 0);
            cyc(($urandom_range(0, 7) == 0), 1'($urandom_range(0, 1)),
                DW'($urandom), ($urandom_range(0, 3) == 0),
                ($urandom_range(0, 7) == 0), ev,
                1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
        end

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule